// File: doc/BRIEF.md
# Two-Way Set-Associative Translation Buffer

This block caches page translations for a 32-bit address space with 4 KB pages. A lookup presents an effective address and a store flag. One cycle after the request is accepted, the block reports hit or miss and the physical address. The upper 20 bits come from the cached page frame. The lower 12 bits pass through unchanged. Storage is 64 sets of two ways. Each set keeps a single least-recently-used bit that names the next victim.

On a miss the block stops taking requests and raises a table-walk request that carries the missing page number. It holds that request until an external walker acknowledges with the page frame and the entry's current referenced and changed status. It then writes the translation into the chosen way and reopens. The requester retries the access, which now hits.

When a hit would newly set the referenced status, or a store hit would newly set the changed status, the block raises a one-cycle write-back request so the page table can be kept current. A single flush input invalidates every entry. Two instances are used: one for data, driven with a real store flag, and one for instruction fetch, with the store flag tied low.

Top module: `tlb2w`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid`, `walk_req` and `wb_valid` are 0. No entry is valid, so the first lookup misses.
- R2: A request is accepted when `req_valid` and `req_ready` are both 1. Exactly one cycle later `rsp_valid` is 1 for one cycle, with `rsp_hit`. On a hit, `rsp_pa` is {cached frame, `req_ea[11:0]`}.
- R3: A miss drops `req_ready` from the next cycle. `walk_req` is then 1, with `walk_vpn` = `req_ea[31:12]`, held steady until a cycle with `walk_ack` = 1. In that cycle the translation is installed, and `req_ready` returns in the following cycle.
- R4: The set is `req_ea[17:12]` and the tag is `req_ea[31:18]`. Two pages with the same set bits and different tags can both be resident.
- R5: A refill chooses an invalid way first (way 0 before way 1). If both ways are valid, it chooses the least recently used way. A hit or a refill makes the other way of that set the next victim.
- R6: A refill loads the referenced and changed status from `walk_ref` and `walk_chg`. A hit that finds referenced clear raises `wb_valid` in the response cycle, with `wb_ppn` = frame, `wb_ref` = 1 and `wb_chg` = the updated changed status.
- R7: A store hit that finds changed clear raises `wb_valid` with `wb_chg` = 1. A hit whose status needs no change raises no write-back. The entry's status is updated, so a repeat of the same access raises none.
- R8: `flush_all` invalidates every entry in one cycle, and `req_ready` is 0 during that cycle. A later lookup of a page that was resident misses.
- R9: When `flush_all` and the `walk_ack` of an outstanding refill fall in the same cycle, the refilled translation survives the flush and the retry hits.
- R10: While a refill is outstanding, `req_ready` stays 0. A request held at `req_valid` = 1 during that time is not accepted and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_all | input | 1 | Invalidate every entry |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup can be accepted |
| req_ea | input | 32 | Effective address |
| req_store | input | 1 | 1 = store access, 0 = load or fetch |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_pa | output | 32 | Physical address (meaningful on hit) |
| walk_req | output | 1 | Table-walk request |
| walk_vpn | output | 20 | Page number to be walked |
| walk_ack | input | 1 | Walk result present |
| walk_ppn | input | 20 | Returned page frame |
| walk_ref | input | 1 | Returned referenced status |
| walk_chg | input | 1 | Returned changed status |
| wb_valid | output | 1 | Status write-back request |
| wb_ppn | output | 20 | Page frame of the updated entry |
| wb_ref | output | 1 | New referenced status |
| wb_chg | output | 1 | New changed status |

## Verification
Two functions can act on the storage in the same cycle: a global flush and the completion of a refill. The bench makes its walker raise `walk_ack` together with `flush_all`. It then retries the missed page and expects a hit with a fresh write-back. It also expects a miss on a page that was resident before the flush. A lookup request held during a walk is a second collision. It is judged by watching `req_ready` stay low and by confirming that no extra response appears in the scoreboard.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int unsigned EA_W  = 32;
    localparam int unsigned OFS_W = 12;
    localparam int unsigned SET_W = 6;
    localparam int unsigned NWAY  = 2;
    localparam int unsigned PN_W  = EA_W - OFS_W;
    localparam int unsigned TAG_W = PN_W - SET_W;
    localparam int unsigned NSET  = 1 << SET_W;

    typedef logic [PN_W-1:0]  pn_t;
    typedef logic [TAG_W-1:0] tag_t;
    typedef logic [SET_W-1:0] set_t;

    typedef struct packed {
        logic vld;
        tag_t tag;
        pn_t  ppn;
        logic rbit;
        logic cbit;
    } tlbe_t;

    typedef enum logic {ST_LOOKUP, ST_WALK} fsm_t;

    function automatic set_t set_of(pn_t vpn);
        return vpn[SET_W-1:0];
    endfunction

    function automatic tag_t tag_of(pn_t vpn);
        return vpn[PN_W-1:SET_W];
    endfunction
endpackage

// File: rtl/tlb2w_array.sv
module tlb2w_array
    import tlb_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            flush,
    input  set_t            lk_set,
    output tlbe_t [NWAY-1:0] lk_ents,
    input  logic            hit_en,
    input  set_t            hit_set,
    input  logic            hit_way,
    input  logic            hit_store,
    input  logic            fill_en,
    input  set_t            fill_set,
    input  tag_t            fill_tag,
    input  pn_t             fill_ppn,
    input  logic            fill_r,
    input  logic            fill_c
);
    tlbe_t            mem [NSET][NWAY];
    logic [NSET-1:0]  lru;
    logic             vic;
    logic             any_vld;

    assign lk_ents = {mem[lk_set][1], mem[lk_set][0]};

    // victim: empty way first, otherwise the LRU pointer
    always_comb begin
        if (!mem[fill_set][0].vld)      vic = 1'b0;
        else if (!mem[fill_set][1].vld) vic = 1'b1;
        else                            vic = lru[fill_set];
    end

    always_comb begin
        any_vld = 1'b0;
        for (int s = 0; s < NSET; s++)
            for (int w = 0; w < NWAY; w++)
                any_vld = any_vld | mem[s][w].vld;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lru <= '0;
            for (int s = 0; s < NSET; s++)
                for (int w = 0; w < NWAY; w++)
                    mem[s][w].vld <= 1'b0;
        end else begin
            if (flush)
                for (int s = 0; s < NSET; s++)
                    for (int w = 0; w < NWAY; w++)
                        mem[s][w].vld <= 1'b0;
            if (hit_en) begin
                mem[hit_set][hit_way].rbit <= 1'b1;
                if (hit_store) mem[hit_set][hit_way].cbit <= 1'b1;
                lru[hit_set] <= ~hit_way;
            end
            if (fill_en) begin
                mem[fill_set][vic] <= '{vld: 1'b1, tag: fill_tag, ppn: fill_ppn,
                                        rbit: fill_r, cbit: fill_c};
                lru[fill_set] <= ~vic;
            end
        end
    end

    // R9: a refill written in a flush cycle is valid afterwards
    a_r9_fill_survives_flush: assert property (@(posedge clk) disable iff (rst)
        fill_en |=> mem[$past(fill_set)][$past(vic)].vld);

    // R8: a flush without a refill leaves nothing valid
    a_r8_flush_clears: assert property (@(posedge clk) disable iff (rst)
        (flush && !fill_en) |=> !any_vld);

    // R5: after a hit the other way is the victim of that set
    a_r5_hit_moves_lru: assert property (@(posedge clk) disable iff (rst)
        hit_en |=> lru[$past(hit_set)] != $past(hit_way));
endmodule

// File: rtl/tlb2w_walk.sv
module tlb2w_walk
    import tlb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  pn_t  start_vpn,
    input  logic walk_ack,
    output logic walk_req,
    output pn_t  walk_vpn,
    output logic busy,
    output logic fill_en
);
    fsm_t state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_LOOKUP;
            walk_vpn <= '0;
        end else begin
            case (state)
                ST_LOOKUP: if (start) begin
                    state    <= ST_WALK;
                    walk_vpn <= start_vpn;
                end
                ST_WALK: if (walk_ack) state <= ST_LOOKUP;
                default: state <= ST_LOOKUP;
            endcase
        end
    end

    assign walk_req = (state == ST_WALK);
    assign busy     = walk_req;
    assign fill_en  = walk_req && walk_ack;

    // R3: request and page number held until acknowledged
    a_r3_walk_held: assert property (@(posedge clk) disable iff (rst)
        (walk_req && !walk_ack) |=> (walk_req && $stable(walk_vpn)));

    // R3: acknowledge ends the walk
    a_r3_ack_ends: assert property (@(posedge clk) disable iff (rst)
        (walk_req && walk_ack) |=> !walk_req);
endmodule

// File: rtl/tlb2w.sv
module tlb2w
    import tlb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        flush_all,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_ea,
    input  logic        req_store,
    output logic        rsp_valid,
    output logic        rsp_hit,
    output logic [31:0] rsp_pa,
    output logic        walk_req,
    output logic [19:0] walk_vpn,
    input  logic        walk_ack,
    input  logic [19:0] walk_ppn,
    input  logic        walk_ref,
    input  logic        walk_chg,
    output logic        wb_valid,
    output logic [19:0] wb_ppn,
    output logic        wb_ref,
    output logic        wb_chg
);
    pn_t              vpn;
    tlbe_t [NWAY-1:0] ents;
    logic [NWAY-1:0]  way_hit;
    logic             hit, accept, busy, fill_en, hit_way;
    tlbe_t            sel;

    assign vpn    = req_ea[EA_W-1:OFS_W];
    assign accept = req_valid && req_ready;

    for (genvar w = 0; w < NWAY; w++) begin : g_cmp
        assign way_hit[w] = ents[w].vld && (ents[w].tag == tag_of(vpn));
    end

    assign hit     = |way_hit;
    assign hit_way = way_hit[1];
    assign sel     = ents[hit_way];

    tlb2w_array u_arr (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush_all),
        .lk_set    (set_of(vpn)),
        .lk_ents   (ents),
        .hit_en    (accept && hit),
        .hit_set   (set_of(vpn)),
        .hit_way   (hit_way),
        .hit_store (req_store),
        .fill_en   (fill_en),
        .fill_set  (set_of(walk_vpn)),
        .fill_tag  (tag_of(walk_vpn)),
        .fill_ppn  (walk_ppn),
        .fill_r    (walk_ref),
        .fill_c    (walk_chg)
    );

    tlb2w_walk u_walk (
        .clk       (clk),
        .rst       (rst),
        .start     (accept && !hit),
        .start_vpn (vpn),
        .walk_ack  (walk_ack),
        .walk_req  (walk_req),
        .walk_vpn  (walk_vpn),
        .busy      (busy),
        .fill_en   (fill_en)
    );

    assign req_ready = !busy && !flush_all;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_pa    <= '0;
            wb_valid  <= 1'b0;
            wb_ppn    <= '0;
            wb_ref    <= 1'b0;
            wb_chg    <= 1'b0;
        end else begin
            rsp_valid <= accept;
            rsp_hit   <= accept && hit;
            rsp_pa    <= {(hit ? sel.ppn : vpn), req_ea[OFS_W-1:0]};
            wb_valid  <= accept && hit && (!sel.rbit || (req_store && !sel.cbit));
            wb_ppn    <= sel.ppn;
            wb_ref    <= 1'b1;
            wb_chg    <= sel.cbit | req_store;
        end
    end

    // R2: a response only follows an accepted request
    a_r2_rsp_after_accept: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid && req_ready));

    // R2: page offset passes through untranslated
    a_r2_offset_kept: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_pa[OFS_W-1:0] == $past(req_ea[OFS_W-1:0])));

    // R10: no acceptance while a walk is pending
    a_r10_stall_in_walk: assert property (@(posedge clk) disable iff (rst)
        walk_req |-> !req_ready);

    // R6: write-back only alongside a hit response
    a_r6_wb_with_hit: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> (rsp_valid && rsp_hit));

    // R7: a store write-back carries the changed status
    a_r7_store_sets_chg: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && $past(req_store)) |-> wb_chg);
endmodule

// File: tb/tlb2w_tb_top.sv
module tlb2w_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush_all = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_ea = '0;
    logic        req_store = 1'b0;
    logic        rsp_valid, rsp_hit;
    logic [31:0] rsp_pa;
    logic        walk_req;
    logic [19:0] walk_vpn;
    logic        walk_ack = 1'b0;
    logic [19:0] walk_ppn = '0;
    logic        walk_ref = 1'b0;
    logic        walk_chg = 1'b0;
    logic        wb_valid, wb_ref, wb_chg;
    logic [19:0] wb_ppn;

    always #10 clk = ~clk;

    tlb2w dut_i (.*);

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic [31:0] ea;
        bit          hit;
        bit          wb;
        bit          wr;
        bit          wc;
    } exp_t;
    exp_t exp_q[$];

    // bench-side walker control
    int          walk_delay = 2;
    int          wcnt = 0;
    bit          pte_r = 1'b0;
    bit          pte_c = 1'b0;
    bit          flush_with_ack = 1'b0;
    int          flush_cmd = 0;
    int          flush_seen = 0;
    logic [19:0] exp_walk_vpn = '0;

    function automatic logic [19:0] xl(input logic [19:0] v);
        return v ^ 20'h5A5A5;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // walker and flush driver
    always @(negedge clk) begin
        flush_all = 1'b0;
        walk_ack  = 1'b0;
        if (flush_cmd != flush_seen) begin
            flush_all  = 1'b1;
            flush_seen = flush_cmd;
        end
        if (!rst && walk_req) begin
            wcnt++;
            if (wcnt >= walk_delay) begin
                chk(walk_vpn == exp_walk_vpn, "R3 walk_vpn", {12'h0, walk_vpn},
                    {12'h0, exp_walk_vpn});
                walk_ack = 1'b1;
                walk_ppn = xl(walk_vpn);
                walk_ref = pte_r;
                walk_chg = pte_c;
                wcnt = 0;
                if (flush_with_ack) flush_all = 1'b1;
            end
        end
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (rsp_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R10 unexpected response", rsp_pa, 32'h0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(rsp_hit == e.hit, "R2 hit", {31'h0, rsp_hit}, {31'h0, e.hit});
                    if (e.hit)
                        chk(rsp_pa == {xl(e.ea[31:12]), e.ea[11:0]}, "R2 pa",
                            rsp_pa, {xl(e.ea[31:12]), e.ea[11:0]});
                    chk(wb_valid == e.wb, "R6/R7 wb_valid", {31'h0, wb_valid},
                        {31'h0, e.wb});
                    if (e.wb && wb_valid) begin
                        chk(wb_ppn == xl(e.ea[31:12]), "R6 wb_ppn", {12'h0, wb_ppn},
                            {12'h0, xl(e.ea[31:12])});
                        chk({wb_ref, wb_chg} == {e.wr, e.wc}, "R7 wb bits",
                            {30'h0, wb_ref, wb_chg}, {30'h0, e.wr, e.wc});
                    end
                end
            end else if (wb_valid) begin
                chk(1'b0, "R6 wb without response", 32'h1, 32'h0);
            end
        end
    end

    task automatic access(input logic [31:0] ea, input bit st, input bit eh,
                          input bit ewb, input bit ewr, input bit ewc);
        exp_t e;
        @(negedge clk); #1;
        while (!req_ready) begin @(negedge clk); #1; end
        req_valid    = 1'b1;
        req_ea       = ea;
        req_store    = st;
        exp_walk_vpn = ea[31:12];
        e = '{ea: ea, hit: eh, wb: ewb, wr: ewr, wc: ewc};
        exp_q.push_back(e);
        @(negedge clk); #1;
        req_valid = 1'b0;
        while (!req_ready) begin @(negedge clk); #1; end
    endtask

    localparam logic [31:0] PA_A = 32'h0000_3123;
    localparam logic [31:0] PA_B = 32'h0004_3ABC;
    localparam logic [31:0] PA_C = 32'h0008_3004;
    localparam logic [31:0] PA_D = 32'h0000_5010;
    localparam logic [31:0] PA_E = 32'h0004_5020;
    localparam logic [31:0] PA_F = 32'h0000_7777;
    localparam logic [31:0] PA_G = 32'h0000_9FFF;
    localparam logic [31:0] PA_H = 32'h0001_0000;
    localparam logic [31:0] PA_K = 32'h0000_B0F0;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk(req_ready == 1'b1, "R1 req_ready", {31'h0, req_ready}, 32'h1);
        chk(rsp_valid == 1'b0, "R1 rsp_valid", {31'h0, rsp_valid}, 32'h0);
        chk(walk_req == 1'b0, "R1 walk_req", {31'h0, walk_req}, 32'h0);
        chk(wb_valid == 1'b0, "R1 wb_valid", {31'h0, wb_valid}, 32'h0);

        access(PA_A, 0, 0, 0, 0, 0);       // R1 empty -> miss
        access(PA_A, 0, 1, 1, 1, 0);       // R6 first hit sets referenced
        access(PA_A, 0, 1, 0, 0, 0);       // R7 no change needed
        access(PA_A, 1, 1, 1, 1, 1);       // R7 store sets changed
        access(PA_A, 1, 1, 0, 0, 0);       // R7 repeat store silent

        access(PA_B, 0, 0, 0, 0, 0);       // R4 same set, other tag
        access(PA_B, 0, 1, 1, 1, 0);
        access(PA_A, 0, 1, 0, 0, 0);       // R4 both resident

        access(PA_C, 0, 0, 0, 0, 0);       // R5 evicts B (LRU)
        access(PA_A, 0, 1, 0, 0, 0);       // R5 A survived
        access(PA_B, 0, 0, 0, 0, 0);       // R5 B gone, evicts C
        access(PA_B, 0, 1, 1, 1, 0);
        access(PA_A, 0, 1, 0, 0, 0);
        access(PA_C, 0, 0, 0, 0, 0);       // R5 C was evicted

        access(PA_D, 0, 0, 0, 0, 0);       // R5 empty ways first
        access(PA_E, 0, 0, 0, 0, 0);
        access(PA_D, 0, 1, 1, 1, 0);
        access(PA_E, 0, 1, 1, 1, 0);

        pte_r = 1'b1; pte_c = 1'b1;        // R6 status from walker
        access(PA_K, 0, 0, 0, 0, 0);
        access(PA_K, 1, 1, 0, 0, 0);
        pte_r = 1'b0; pte_c = 1'b0;

        // R10: request held during a walk is not accepted
        walk_delay = 6;
        begin
            exp_t e;
            @(negedge clk); #1;
            while (!req_ready) begin @(negedge clk); #1; end
            req_valid = 1'b1; req_ea = PA_G; req_store = 1'b0;
            exp_walk_vpn = PA_G[31:12];
            e = '{ea: PA_G, hit: 1'b0, wb: 1'b0, wr: 1'b0, wc: 1'b0};
            exp_q.push_back(e);
            @(negedge clk); #1;
            req_ea = PA_H;
            for (int i = 0; i < 3; i++) begin
                chk(req_ready == 1'b0, "R10 ready low in walk", {31'h0, req_ready}, 32'h0);
                @(negedge clk); #1;
            end
            req_valid = 1'b0;
            while (!req_ready) begin @(negedge clk); #1; end
        end
        walk_delay = 2;
        access(PA_G, 0, 1, 1, 1, 0);       // R10 refill of held miss done

        // R8 flush
        flush_cmd++;
        @(negedge clk); #2;
        chk(req_ready == 1'b0, "R8 ready low in flush", {31'h0, req_ready}, 32'h0);
        access(PA_A, 0, 0, 0, 0, 0);       // R8 was resident, now misses
        access(PA_A, 0, 1, 1, 1, 0);

        // R9 flush coincides with walk acknowledge
        flush_with_ack = 1'b1;
        access(PA_F, 0, 0, 0, 0, 0);
        flush_with_ack = 1'b0;
        access(PA_F, 0, 1, 1, 1, 0);       // R9 refill survived
        access(PA_A, 0, 0, 0, 0, 0);       // R9 flush still took effect

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all responses seen", exp_q.size(), 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule